// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines and resolves them with a fixed priority. It raises one interrupt line toward the processor and answers a two-pulse acknowledge sequence with a vector byte. The vector is built from a programmable 5-bit base and the 3-bit index of the winning line. Each line has its own mask bit. A set of in-service bits records which levels the processor is handling. A level in service holds off itself and every lower-priority level until an end-of-interrupt command clears it.

Units chain to 64 levels: one master and up to eight slaves. In the master, any input can be marked as fed by a slave. When such an input wins the first acknowledge pulse, the master drives that input's index on three cascade lines and stays silent on the vector. The slave whose programmed ID matches the cascade lines on the second pulse takes its own winner into service and returns the vector. Each request line works in one of two sensing modes. In level mode the pending bit follows the synchronised input. In edge mode, once a request has been acknowledged, the line must go low before it can request again.

The register port is a plain synchronous interface. Every access lasts one clock cycle, and reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, irq_out is low, every mask bit is set, the in-service register is empty, vec_valid is low and cas_drive is low.
- R2: A request whose mask bit is set never drives irq_out high. An unmasked pending request that is not held off by in-service bits drives irq_out high two clock edges after the input rises: one edge to sample the input and one for the output register.
- R3: Priority is fixed, with input 0 highest and input 7 lowest. A request is held off when an in-service bit of equal or higher priority is set, so a higher-priority request can still nest over a level already in service.
- R4: On the first acknowledge pulse a master or standalone unit moves the winning request into the in-service register. In edge mode the pending bit of that input also clears at once.
- R5: On the clock edge that samples the second acknowledge pulse, a unit that supplies the vector sets vec_valid for exactly one cycle with vec = {base[4:0], index[2:0]}.
- R6: An end-of-interrupt command clears only the lowest-index (highest-priority) set in-service bit.
- R7: In edge mode a request is posted only when the input was sampled low before it rose. An acknowledged input that stays high posts nothing more. An input that falls before it is acknowledged withdraws its request.
- R8: In level mode the pending register equals the sampled inputs, whatever the mask.
- R9: When a master's winner is marked slave-fed in the cascade map, the first acknowledge pulse drives cas_out = winner index with cas_drive high. cas_drive stays high until the edge that samples the second pulse. The master gives no vector for that sequence.
- R10: A slave acts only on the second pulse and only when cas_in equals its ID. It then moves its winner into service and supplies the vector. When the ID does not match, its in-service register and vec_valid are left unchanged.
- R11: An acknowledge sequence with no eligible request returns index 7 in the vector and leaves the in-service register unchanged.
- R12: A write with addr=0 is a command, selected by wdata[7:6]:
  - 00 points the data port at the mask (wdata[0]=0) or at the cascade map (wdata[0]=1).
  - 01 is end of interrupt.
  - 10 loads the base from wdata[4:0].
  - 11 loads the configuration: edge mode in wdata[0], slave role in wdata[1], slave ID in wdata[4:2].
  
  A write with addr=1 goes to the register the data port points at. A read with addr=0 returns the pending register and a read with addr=1 returns the in-service register. rdata is zero when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register port select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| addr | input | 1 | Command (0) or data port (1) select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (pending or in-service register) |
| irq_in | input | 8 | Interrupt request inputs, index 0 highest |
| irq_out | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge pulse, one cycle per pulse |
| vec | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector valid for one cycle |
| cas_in | input | 3 | Cascade ID seen by a slave |
| cas_out | output | 3 | Cascade ID driven by a master |
| cas_drive | output | 1 | Master is driving cas_out |

## Verification
The bench drives every input on a falling edge and samples on a later falling edge. An input change shows in the pending register after one rising edge and on irq_out after two, so each irq_out check waits two falling edges. The in-service bits, the cleared edge latch and the cascade outputs are due on the rising edge that samples the first acknowledge pulse. The vector is due on the rising edge that samples the second pulse, so each of these is checked on the falling edge right after it. Through a slave, the master's irq_out is due four edges after the slave's input rises, because each unit adds two registers.

// File: rtl/pic_pkg.sv
// Shared constants and helpers for the priority interrupt controller.
// Assumes eight inputs, 3-bit cascade IDs and an 8-bit vector.
package pic_pkg;
    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;

    // Command codes carried in wdata[7:6] of an addr=0 write
    typedef enum logic [1:0] {
        CMD_PORT = 2'b00,
        CMD_EOI  = 2'b01,
        CMD_BASE = 2'b10,
        CMD_CFG  = 2'b11
    } cmd_e;
endpackage

// File: rtl/pic_req_latch.sv
// Request sampling: registers each input once and forms the pending bits.
// In level mode pending follows the sampled input. In edge mode a per-input
// arm flag is set while the input is low and is cleared by an acknowledge,
// so an acknowledged input must go low before it can request again.
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic in_q;
            logic armed;

            // Sample the input and keep the arm flag for edge sensing
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    in_q  <= 1'b0;
                    armed <= 1'b0;
                end else begin
                    in_q  <= irq_in[g];
                    armed <= (armed & ~clr[g]) | ~in_q;
                end
            end

            assign pend[g] = in_q & (armed | ~edge_mode);
        end
    endgenerate
endmodule

// File: rtl/pic_prio_resolve.sv
// Fixed-priority resolver: index 0 highest. Scans from the top; an
// in-service bit stops the scan, so equal and lower levels are held off.
// Purely combinational.
module pic_prio_resolve #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     isr,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Find the first request above the highest in-service level
    always_comb begin
        logic stop;
        valid = 1'b0;
        idx   = '0;
        stop  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop = 1'b1;
                end else if (req[i]) begin
                    valid = 1'b1;
                    idx   = IDX_W'(i);
                    stop  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic_ack_seq.sv
// Acknowledge sequencer and in-service register. Tracks the pulse phase.
// A master takes its winner into service on the first pulse and may drive
// the cascade ID. The vector is given on the second pulse by a master with
// a local winner, or by a slave whose ID matches cas_in. End of interrupt
// clears the lowest-index in-service bit.
module pic_ack_seq #(
    parameter int N      = 8,
    parameter int IDX_W  = 3,
    parameter int BASE_W = 5,
    localparam int VW    = BASE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              eoi,
    input  logic              slave_role,
    input  logic [IDX_W-1:0]  slave_id,
    input  logic [IDX_W-1:0]  cas_in,
    input  logic [N-1:0]      cas_map,
    input  logic [BASE_W-1:0] base,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [N-1:0]      isr,
    output logic [N-1:0]      clr,
    output logic [VW-1:0]     vec,
    output logic              vec_valid,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_drive
);
    logic             phase;
    logic [IDX_W-1:0] held_idx;
    logic             held_casc;
    logic             first_p;
    logic             second_p;
    logic             id_hit;
    logic             take;
    logic [N-1:0]     eoi_mask;

    // Decode the pulse phase and decide whether a winner enters service
    always_comb begin
        first_p  = ack & ~phase;
        second_p = ack & phase;
        id_hit   = slave_role & second_p & (cas_in == slave_id);
        take     = slave_role ? (id_hit & win_valid) : (first_p & win_valid);
        clr      = take ? (N'(1) << win_idx) : '0;
        eoi_mask = eoi ? (isr & (~isr + N'(1))) : '0;
    end

    // In-service register: set on take, lowest bit cleared on EOI
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_mask) | clr;
    end

    // Pulse phase toggles on every acknowledge pulse
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= 1'b0;
        else if (ack) phase <= ~phase;
    end

    // Vector, cascade ID and held winner for the second pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec       <= '0;
            vec_valid <= 1'b0;
            cas_out   <= '0;
            cas_drive <= 1'b0;
            held_idx  <= '0;
            held_casc <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            if (!slave_role) begin
                if (first_p) begin
                    held_idx  <= win_valid ? win_idx : '1;
                    held_casc <= win_valid & cas_map[win_idx];
                    cas_drive <= win_valid & cas_map[win_idx];
                    cas_out   <= win_idx;
                end
                if (second_p) begin
                    cas_drive <= 1'b0;
                    if (!held_casc) begin
                        vec_valid <= 1'b1;
                        vec       <= {base, held_idx};
                    end
                end
            end else if (id_hit) begin
                vec_valid <= 1'b1;
                vec       <= {base, (win_valid ? win_idx : {IDX_W{1'b1}})};
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top level: register port, request latch, resolver and acknowledge
// sequencer. Assumes single-cycle register strobes and ack pulses that are
// synchronous to clk. irq_out is registered from the resolver.
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              irq_out,
    input  logic              ack,
    output logic [DATA_W-1:0] vec,
    output logic              vec_valid,
    input  logic [IDX_W-1:0]  cas_in,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_drive
);
    logic [NUM_IN-1:0] mask;
    logic [NUM_IN-1:0] cas_map;
    logic [BASE_W-1:0] base;
    logic              edge_mode;
    logic              slave_role;
    logic [IDX_W-1:0]  slave_id;
    logic              port_map;
    logic [NUM_IN-1:0] pend;
    logic [NUM_IN-1:0] isr;
    logic [NUM_IN-1:0] clr;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic              wr_cmd;
    logic              wr_data;
    logic              eoi;
    cmd_e              cmd;

    // Decode register writes
    always_comb begin
        cmd     = cmd_e'(wdata[7:6]);
        wr_cmd  = cs & wr & ~addr;
        wr_data = cs & wr & addr;
        eoi     = wr_cmd & (cmd == CMD_EOI);
    end

    // Configuration registers written through the command and data ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= '1;
            cas_map    <= '0;
            base       <= '0;
            edge_mode  <= 1'b0;
            slave_role <= 1'b0;
            slave_id   <= '0;
            port_map   <= 1'b0;
        end else begin
            if (wr_cmd) begin
                case (cmd)
                    CMD_PORT: port_map <= wdata[0];
                    CMD_BASE: base     <= wdata[BASE_W-1:0];
                    CMD_CFG: begin
                        edge_mode  <= wdata[0];
                        slave_role <= wdata[1];
                        slave_id   <= wdata[2 +: IDX_W];
                    end
                    default: ;
                endcase
            end
            if (wr_data) begin
                if (port_map) cas_map <= wdata;
                else          mask    <= wdata;
            end
        end
    end

    // Combinational read mux
    always_comb begin
        rdata = (cs & rd) ? (addr ? isr : pend) : '0;
    end

    pic_req_latch #(.N(NUM_IN)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .irq_in    (irq_in),
        .clr       (clr),
        .pend      (pend)
    );

    pic_prio_resolve #(.N(NUM_IN), .IDX_W(IDX_W)) u_prio (
        .req   (pend & ~mask),
        .isr   (isr),
        .valid (win_valid),
        .idx   (win_idx)
    );

    pic_ack_seq #(.N(NUM_IN), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack),
        .eoi        (eoi),
        .slave_role (slave_role),
        .slave_id   (slave_id),
        .cas_in     (cas_in),
        .cas_map    (cas_map),
        .base       (base),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .isr        (isr),
        .clr        (clr),
        .vec        (vec),
        .vec_valid  (vec_valid),
        .cas_out    (cas_out),
        .cas_drive  (cas_drive)
    );

    // Interrupt output register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= win_valid;
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Assertion checker for prio_irq_ctrl, attached by bind below.
// Observes ports and internal mask, pending and in-service state.
module prio_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_out,
    input logic       vec_valid,
    input logic       cas_drive,
    input logic       slave_role,
    input logic [7:0] mask,
    input logic [7:0] pend,
    input logic [7:0] isr
);
    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mask == 8'hFF && isr == 8'h00 && !irq_out && !vec_valid && !cas_drive));

    // R2: irq_out only follows an unmasked pending request
    assert_masked_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(pend & ~mask)));

    // R4: at most one level enters service per cycle
    assert_one_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);

    // R5: vector strobe lasts one cycle
    assert_vec_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R9: only a master drives the cascade lines
    assert_cas_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cas_drive |-> !slave_role);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_out    (irq_out),
    .vec_valid  (vec_valid),
    .cas_drive  (cas_drive),
    .slave_role (slave_role),
    .mask       (mask),
    .pend       (pend),
    .isr        (isr)
);

// File: tb/prio_irq_ctrl_test.sv
// Bench: master (uut) with a slave (uut_slave) on master input 3.
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_m = 1'b0, cs_s = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_m, rdata_s;
    logic [7:0] m_in = '0, s_in = '0;
    logic [7:0] m_irq;
    logic       ack = 1'b0;
    logic       irq_m, irq_s;
    logic [7:0] vec_m, vec_s;
    logic       vv_m, vv_s;
    logic [2:0] cas_m, cas_s_unused;
    logic       cd_m, cd_s;
    int         checks = 0, errors = 0;
    logic [7:0] mask_r;

    always #5 clk = ~clk;

    assign m_irq = {m_in[7:4], irq_s, m_in[2:0]};

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs(cs_m), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata_m), .irq_in(m_irq), .irq_out(irq_m),
        .ack(ack), .vec(vec_m), .vec_valid(vv_m), .cas_in(3'd0),
        .cas_out(cas_m), .cas_drive(cd_m)
    );

    prio_irq_ctrl uut_slave (
        .clk(clk), .rst_n(rst_n), .cs(cs_s), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata_s), .irq_in(s_in), .irq_out(irq_s),
        .ack(ack), .vec(vec_s), .vec_valid(vv_s), .cas_in(cas_m),
        .cas_out(cas_s_unused), .cas_drive(cd_s)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic to_slave, input logic a, input logic [7:0] d);
        cs_m = ~to_slave; cs_s = to_slave; wr = 1'b1; addr = a; wdata = d;
        cyc(1);
        cs_m = 1'b0; cs_s = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic to_slave, input logic a, output logic [7:0] d);
        cs_m = ~to_slave; cs_s = to_slave; rd = 1'b1; addr = a;
        #1;
        d = to_slave ? rdata_s : rdata_m;
        cs_m = 1'b0; cs_s = 1'b0; rd = 1'b0;
        #1;
    endtask

    task automatic pulse();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    function automatic logic [2:0] top_idx(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) top_idx = 3'(i);
    endfunction

    function automatic logic [7:0] exp_vec(input logic [4:0] b, input logic [2:0] i);
        return {b, i};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] req;
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        cyc(4);
        // R1: state during reset
        chk("R1 irq during reset", irq_m, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 irq", irq_m, 0);
        chk("R1 vec_valid", vv_m, 0);
        chk("R1 cas_drive", cd_m, 0);
        rreg(0, 1, r); chk("R1 isr empty", r, 8'h00);

        // R2/R8: masked after reset; pending still follows input
        m_in = 8'h01; cyc(2);
        chk("R2 masked no irq", irq_m, 0);
        rreg(0, 0, r); chk("R8 pending follows input", r, 8'h01);
        chk("R12 rdata idle zero", rdata_m, 8'h00);
        m_in = 8'h00; cyc(2);

        // R12: program master base 0x11, cascade map bit 3, mask 0
        wreg(0, 0, 8'h91);
        wreg(0, 0, 8'h01); wreg(0, 1, 8'h08);
        wreg(0, 0, 8'h00); wreg(0, 1, 8'h00);
        // slave: role slave, ID 3, base 0x0A, mask 0
        wreg(1, 0, 8'hCE);
        wreg(1, 0, 8'h8A);
        wreg(1, 1, 8'h00);
        cyc(2);

        // Random level-mode sweep (R2, R3, R4, R5, R6, R8)
        for (int k = 0; k < 40; k++) begin
            mask_r = 8'($urandom()) & 8'hF7;
            if (k % 4 == 0) mask_r = 8'h00;
            wreg(0, 1, mask_r);
            m_in = 8'($urandom()) & 8'hF7;
            cyc(2);
            req = m_in & ~mask_r;
            chk("R2 irq vs unmasked", irq_m, (req != 0));
            rreg(0, 0, r); chk("R8 pending", r, m_in);
            if (req != 0) begin
                pulse();
                rreg(0, 1, r); chk("R4 isr winner", r, 8'(1) << top_idx(req));
                pulse();
                chk("R5 vec_valid", vv_m, 1);
                chk("R3 vec priority", vec_m, exp_vec(5'h11, top_idx(req)));
                wreg(0, 0, 8'h40);
                rreg(0, 1, r); chk("R6 isr cleared", r, 8'h00);
            end
            m_in = 8'h00; cyc(2);
        end
        wreg(0, 1, 8'h00);

        // R3/R6: nesting and EOI order
        m_in = 8'h24; cyc(2);
        chk("R3 irq", irq_m, 1);
        pulse(); pulse();
        chk("R3 vec idx2", vec_m, exp_vec(5'h11, 3'd2));
        chk("R3 lower held off", irq_m, 0);
        m_in = 8'h26; cyc(2);
        chk("R3 higher nests", irq_m, 1);
        pulse(); pulse();
        chk("R3 vec idx1", vec_m, exp_vec(5'h11, 3'd1));
        rreg(0, 1, r); chk("R3 isr two levels", r, 8'h06);
        wreg(0, 0, 8'h40);
        rreg(0, 1, r); chk("R6 lowest cleared", r, 8'h04);
        wreg(0, 0, 8'h40);
        rreg(0, 1, r); chk("R6 isr empty", r, 8'h00);
        m_in = 8'h20; cyc(2);
        chk("R3 idx5 now served", irq_m, 1);
        pulse(); pulse();
        chk("R3 vec idx5", vec_m, exp_vec(5'h11, 3'd5));
        wreg(0, 0, 8'h40);
        m_in = 8'h00; cyc(2);

        // R11: spurious acknowledge
        pulse(); pulse();
        chk("R11 vec_valid", vv_m, 1);
        chk("R11 vec idx7", vec_m, exp_vec(5'h11, 3'd7));
        rreg(0, 1, r); chk("R11 isr unchanged", r, 8'h00);

        // R9/R10: cascade through slave on master input 3
        s_in = 8'h20; cyc(4);
        chk("R9 master irq via slave", irq_m, 1);
        pulse();
        chk("R9 cas_drive", cd_m, 1);
        chk("R9 cas_out", cas_m, 3);
        rreg(0, 1, r); chk("R9 master isr", r, 8'h08);
        pulse();
        chk("R9 master no vector", vv_m, 0);
        chk("R9 cas released", cd_m, 0);
        chk("R10 slave vec_valid", vv_s, 1);
        chk("R10 slave vec", vec_s, exp_vec(5'h0A, 3'd5));
        rreg(1, 1, r); chk("R10 slave isr", r, 8'h20);
        wreg(1, 0, 8'h40); wreg(0, 0, 8'h40);
        s_in = 8'h00; cyc(4);

        // R10: ID mismatch
        wreg(1, 0, 8'hCA);
        s_in = 8'h20; cyc(4);
        pulse(); pulse();
        chk("R10 mismatch no vector", vv_s, 0);
        chk("R10 master silent", vv_m, 0);
        rreg(1, 1, r); chk("R10 slave isr unchanged", r, 8'h00);
        wreg(0, 0, 8'h40);
        s_in = 8'h00; cyc(4);

        // R7: edge mode on master
        wreg(0, 0, 8'hC1);
        cyc(2);
        m_in = 8'h40; cyc(2);
        chk("R7 edge posts", irq_m, 1);
        pulse();
        rreg(0, 0, r); chk("R4 edge pending cleared", r, 8'h00);
        pulse();
        chk("R7 vec idx6", vec_m, exp_vec(5'h11, 3'd6));
        wreg(0, 0, 8'h40);
        cyc(3);
        chk("R7 held high no repost", irq_m, 0);
        m_in = 8'h00; cyc(1);
        m_in = 8'h40; cyc(2);
        chk("R7 re-armed", irq_m, 1);
        m_in = 8'h00; cyc(2);
        chk("R7 withdrawn", irq_m, 0);

        report();
        $finish;
    end
endmodule